// File: doc/BRIEF.md
# Buffered Serial Transmitter with Parity

This block turns parallel words into an asynchronous serial stream on one output line. A host writes a word of 5 to 9 bits through a simple write strobe. The word waits in a one-entry holding stage and then moves into a shift register, which sends it out as a framed character. The frame has a low start bit, the data bits least significant first, an optional parity bit, and one or two high stop bits.

Bit timing comes from an external baud-tick strobe. Each bit lasts 16 ticks, or 8 ticks when double speed is selected. While one frame is shifting out, the host can already load the next word. That word is handed over exactly when the last stop bit ends, so consecutive frames follow each other with no idle time between them.

Two status outputs tell the host what is happening. One says the holding stage can take a word. The other says every frame has fully left the line and nothing is waiting.

Top module: `sertx_core`

## Requirements
- R1: After reset the line is high, `buf_empty` is 1 and `tx_done` is 0.
- R2: The line idles high. A frame is one low start bit, then the data bits least significant first, then the parity bit when enabled, then high stop bits.
- R3: `cfg_data_bits` selects 5, 6, 7, 8 or 9 data bits. A value below 5 acts as 5 and a value above 9 acts as 9. Data bits 0 to 7 come from `wr_data`, and data bit 8 comes from `wr_bit8`, captured with the same write.
- R4: `cfg_parity` selects the parity: 2'b00 and 2'b01 send no parity bit. 2'b10 sends even parity, which is the XOR of the data bits in use. 2'b11 sends odd parity, which is the inverse of that XOR.
- R5: `cfg_two_stop` = 0 sends one stop bit and 1 sends two.
- R6: Each bit lasts 16 baud ticks, or 8 ticks when `cfg_double_speed` is 1. The line changes only at a bit boundary.
- R7: A write is accepted only in a cycle where `buf_empty` is 1. A write while `buf_empty` is 0 is ignored and adds no frame.
- R8: If no frame is shifting, an accepted word moves into the shift register one clock after it is written. In that same cycle the start bit appears on the line and `buf_empty` returns to 1.
- R9: If a word is waiting when the last stop bit ends, its start bit begins in the very next cycle, with no idle time on the line.
- R10: `tx_done` sets one cycle after the last stop bit ends with no word waiting. It clears in the cycle after a write is accepted.
- R11: The frame format and bit length are captured when the word moves into the shift register. Configuration changes during a frame do not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle oversampling tick strobe |
| cfg_data_bits | input | 4 | Number of data bits, 5 to 9 |
| cfg_parity | input | 2 | Parity mode: 0x/none, 10/even, 11/odd |
| cfg_two_stop | input | 1 | Selects two stop bits when 1 |
| cfg_double_speed | input | 1 | Selects 8 ticks per bit when 1 |
| wr_en | input | 1 | Write strobe for the holding stage |
| wr_data | input | 8 | Data bits 0 to 7 |
| wr_bit8 | input | 1 | Data bit 8, used in 9-bit frames |
| tx_out | output | 1 | Serial line |
| buf_empty | output | 1 | Holding stage can take a word |
| tx_done | output | 1 | All frames have finished and nothing is waiting |

## Verification
A bench receiver decodes the line and compares it, tick by tick, against a frame built from the word and the configuration captured at the write. It is fed random words under random combinations of width, parity, stop count and speed, with tick strobes that are sometimes dense and sometimes sparse. That separates errors in bit order, parity polarity, frame length and bit duration.

Directed patterns cover further cases:
- A write issued into a full holding stage separates dropped words from ignored ones.
- Words queued during a frame tell gapless handover apart from an idle gap.
- A configuration change in the middle of a frame shows whether the format is captured at load time.
- Pairs of 9-bit words that differ only in bit 8 show whether that bit comes from its own input.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  localparam int DMAX    = 9;
  localparam int DMIN    = 5;
  localparam int FRAME_W = 1 + DMAX + 1 + 2;
  localparam int LEN_W   = $clog2(FRAME_W + 1);

  typedef enum logic [1:0] {
    PAR_OFF     = 2'b00,
    PAR_OFF_ALT = 2'b01,
    PAR_EVEN    = 2'b10,
    PAR_ODD     = 2'b11
  } par_mode_e;

  typedef struct packed {
    logic [FRAME_W-1:0] bits;
    logic [LEN_W-1:0]   len;
    logic               fast;
  } frame_t;

endpackage

// File: rtl/sertx_bitclk.sv
module sertx_bitclk #(
  parameter int TICKS_NORMAL = 16,
  parameter int TICKS_FAST   = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic fast,
  input  logic baud_tick,
  output logic bit_end
);

  localparam int CW = $clog2(TICKS_NORMAL);
  localparam logic [CW-1:0] LAST_N = CW'(TICKS_NORMAL - 1);
  localparam logic [CW-1:0] LAST_F = CW'(TICKS_FAST - 1);

  logic [CW-1:0] cnt_q, cnt_d, last;

  always_comb begin
    last    = fast ? LAST_F : LAST_N;
    bit_end = run && baud_tick && (cnt_q == last);
    cnt_d   = cnt_q;
    if (!run)
      cnt_d = '0;
    else if (baud_tick)
      cnt_d = bit_end ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_TICK_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt_q <= last) else $error("tick count beyond bit length"); // R6

endmodule

// File: rtl/sertx_holding.sv
module sertx_holding #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_word,
  input  logic         take,
  output logic         accept,
  output logic         valid,
  output logic [W-1:0] word
);

  logic         valid_q, valid_d;
  logic [W-1:0] word_q, word_d;

  always_comb begin
    accept  = wr_en && !valid_q;
    valid_d = valid_q;
    word_d  = word_q;
    if (take)
      valid_d = 1'b0;
    if (accept) begin
      valid_d = 1'b1;
      word_d  = wr_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      word_q  <= '0;
    end else begin
      valid_q <= valid_d;
      word_q  <= word_d;
    end
  end

  assign valid = valid_q;
  assign word  = word_q;

  AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q && !take |=> valid_q && $stable(word_q)) else $error("waiting word lost"); // R7

endmodule

// File: rtl/sertx_framer.sv
module sertx_framer
  import sertx_pkg::*;
(
  input  logic [DMAX-1:0] word,
  input  logic [3:0]      cfg_data_bits,
  input  logic [1:0]      cfg_parity,
  input  logic            cfg_two_stop,
  input  logic            cfg_double_speed,
  output frame_t          frame
);

  par_mode_e     pm;
  logic [3:0]    nd;
  logic          par_en;
  logic          pbit;
  logic [DMAX-1:0] used;

  always_comb begin
    pm = par_mode_e'(cfg_parity);
    if (cfg_data_bits < 4'(DMIN))      nd = 4'(DMIN);
    else if (cfg_data_bits > 4'(DMAX)) nd = 4'(DMAX);
    else                               nd = cfg_data_bits;
    par_en = (pm == PAR_EVEN) || (pm == PAR_ODD);
    for (int i = 0; i < DMAX; i++)
      used[i] = word[i] && (4'(i) < nd);
    pbit = (^used) ^ (pm == PAR_ODD);

    frame.bits = '1;
    frame.bits[0] = 1'b0;
    for (int j = 1; j < FRAME_W; j++) begin
      if (j <= DMAX && 4'(j - 1) < nd)
        frame.bits[j] = word[(j - 1) % DMAX];
      else if (par_en && 4'(j) == nd + 4'd1)
        frame.bits[j] = pbit;
    end
    frame.len  = LEN_W'(nd) + LEN_W'(1) + LEN_W'(par_en) + (cfg_two_stop ? LEN_W'(2) : LEN_W'(1));
    frame.fast = cfg_double_speed;
  end

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
  import sertx_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  frame_t frame_in,
  input  logic   bit_end,
  output logic   busy,
  output logic   fast,
  output logic   line,
  output logic   frame_end
);

  logic [FRAME_W-1:0] sreg_q, sreg_d;
  logic [LEN_W-1:0]   left_q, left_d;
  logic               busy_q, busy_d;
  logic               fast_q, fast_d;

  always_comb begin
    frame_end = busy_q && bit_end && (left_q == LEN_W'(1));
    sreg_d = sreg_q;
    left_d = left_q;
    busy_d = busy_q;
    fast_d = fast_q;
    if (load) begin
      sreg_d = frame_in.bits;
      left_d = frame_in.len;
      busy_d = 1'b1;
      fast_d = frame_in.fast;
    end else if (frame_end) begin
      sreg_d = '1;
      left_d = '0;
      busy_d = 1'b0;
    end else if (busy_q && bit_end) begin
      sreg_d = {1'b1, sreg_q[FRAME_W-1:1]};
      left_d = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '1;
      left_q <= '0;
      busy_q <= 1'b0;
      fast_q <= 1'b0;
    end else begin
      sreg_q <= sreg_d;
      left_q <= left_d;
      busy_q <= busy_d;
      fast_q <= fast_d;
    end
  end

  assign busy = busy_q;
  assign fast = fast_q;
  assign line = busy_q ? sreg_q[0] : 1'b1;

  AST_BIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !bit_end && !load |=> $stable(line)) else $error("line moved inside a bit"); // R6

  AST_END_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end && !load |=> !busy_q && line) else $error("line not idle after frame"); // R2

endmodule

// File: rtl/sertx_core.sv
module sertx_core
  import sertx_pkg::*;
#(
  parameter int TICKS_NORMAL = 16,
  parameter int TICKS_FAST   = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic [3:0] cfg_data_bits,
  input  logic [1:0] cfg_parity,
  input  logic       cfg_two_stop,
  input  logic       cfg_double_speed,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       wr_bit8,
  output logic       tx_out,
  output logic       buf_empty,
  output logic       tx_done
);

  logic            accept, hold_valid, load;
  logic [DMAX-1:0] hold_word;
  frame_t          frame;
  logic            busy, fast, bit_end, frame_end;
  logic            done_q, done_d;

  sertx_holding #(.W(DMAX)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_word ({wr_bit8, wr_data}),
    .take    (load),
    .accept  (accept),
    .valid   (hold_valid),
    .word    (hold_word)
  );

  sertx_framer u_framer (
    .word             (hold_word),
    .cfg_data_bits    (cfg_data_bits),
    .cfg_parity       (cfg_parity),
    .cfg_two_stop     (cfg_two_stop),
    .cfg_double_speed (cfg_double_speed),
    .frame            (frame)
  );

  sertx_bitclk #(
    .TICKS_NORMAL (TICKS_NORMAL),
    .TICKS_FAST   (TICKS_FAST)
  ) u_bitclk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (busy),
    .fast      (fast),
    .baud_tick (baud_tick),
    .bit_end   (bit_end)
  );

  sertx_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .frame_in  (frame),
    .bit_end   (bit_end),
    .busy      (busy),
    .fast      (fast),
    .line      (tx_out),
    .frame_end (frame_end)
  );

  always_comb begin
    load   = hold_valid && (!busy || frame_end);
    done_d = done_q;
    if (accept)
      done_d = 1'b0;
    else if (frame_end && !load)
      done_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_d;
  end

  assign buf_empty = !hold_valid;
  assign tx_done   = done_q;

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !tx_out && busy) else $error("no start bit after load"); // R8

  AST_LOAD_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    load && !accept |=> buf_empty) else $error("holding stage not freed"); // R8

  AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !tx_done) else $error("done flag kept after write"); // R10

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> buf_empty && tx_out && !busy) else $error("done while active"); // R10

endmodule

// File: tb/sertx_core_bench.sv
module sertx_core_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 150000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       baud_tick;
  logic [3:0] cfg_data_bits;
  logic [1:0] cfg_parity;
  logic       cfg_two_stop;
  logic       cfg_double_speed;
  logic       wr_en;
  logic [7:0] wr_data;
  logic       wr_bit8;
  logic       tx_out, buf_empty, tx_done;

  sertx_core #(.TICKS_NORMAL(16), .TICKS_FAST(8)) u_sertx_core (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
    .cfg_data_bits(cfg_data_bits), .cfg_parity(cfg_parity),
    .cfg_two_stop(cfg_two_stop), .cfg_double_speed(cfg_double_speed),
    .wr_en(wr_en), .wr_data(wr_data), .wr_bit8(wr_bit8),
    .tx_out(tx_out), .buf_empty(buf_empty), .tx_done(tx_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;

  // expected word queue, captured at accepted writes
  logic [8:0] q_word [0:511];
  int         q_nd   [0:511];
  int         q_par  [0:511];
  bit         q_two  [0:511];
  bit         q_fast [0:511];
  int q_head = 0, q_tail = 0, frames_rx = 0, words_in = 0;

  int tick_period = 1, tick_cnt = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [12:0] exp_frame(input logic [8:0] d, input int nd, input int par,
                                            input bit two, output int len);
    logic [12:0] b;
    logic ones;
    int pos;
    b = '1;
    b[0] = 1'b0;
    ones = 1'b0;
    for (int i = 0; i < nd; i++) begin
      b[1+i] = d[i];
      ones ^= d[i];
    end
    pos = 1 + nd;
    if (par >= 2) begin
      b[pos] = (par == 3) ? ~ones : ones;
      pos++;
    end
    len = pos + (two ? 2 : 1);
    return b;
  endfunction

  // accepted-write indicator seen at the clock edge
  logic wr_acc_edge;
  always @(posedge clk) wr_acc_edge <= wr_en && buf_empty;

  // tick generator and line receiver, both on the falling edge
  bit rx_busy = 0, rx_bad = 0, pend_end = 0, end_hold_full = 0;
  int rx_t, rx_len, rx_spb, rx_badidx;
  logic [12:0] rx_bits;

  always @(negedge clk) begin
    if (tick_cnt >= tick_period - 1) begin tick_cnt = 0; baud_tick = 1'b1; end
    else begin tick_cnt = tick_cnt + 1; baud_tick = 1'b0; end
    if (rst_n === 1'b1) begin
      if (pend_end) begin
        pend_end = 0;
        if (end_hold_full)
          chk(tx_out == 1'b0 && buf_empty == 1'b1, "R9", "next start bit without gap", int'(tx_out), 0);
        else if (!wr_acc_edge)
          chk(tx_done == 1'b1 && tx_out == 1'b1, "R10", "done after final stop bit", int'(tx_done), 1);
      end
      if (!rx_busy && tx_out == 1'b0) begin
        if (q_head == q_tail) begin
          chk(0, "R7", "frame without accepted word", frames_rx, words_in);
        end else begin
          rx_bits = exp_frame(q_word[q_head], q_nd[q_head], q_par[q_head], q_two[q_head], rx_len);
          rx_spb = q_fast[q_head] ? 8 : 16;
          q_head = (q_head + 1) % 512;
          rx_busy = 1; rx_t = 0; rx_bad = 0; rx_badidx = 0;
        end
      end
      if (rx_busy) begin
        if (tx_out !== rx_bits[rx_t / rx_spb] && !rx_bad) begin
          rx_bad = 1; rx_badidx = rx_t;
        end
        if (baud_tick) begin
          rx_t++;
          if (rx_t == rx_len * rx_spb) begin
            rx_busy = 0;
            frames_rx++;
            // R2 R3 R4 R5 R6: whole frame, tick by tick
            chk(!rx_bad, "R2 R3 R4 R5 R6", "frame bit at tick (actual=tick index)", rx_badidx, int'(rx_bits));
            pend_end = 1;
            end_hold_full = !buf_empty;
          end
        end
      end
    end
  end

  task automatic write_word(input logic [7:0] d, input logic b8, output bit acc);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; wr_bit8 = b8;
    acc = buf_empty;
    if (acc) begin
      q_word[q_tail] = {b8, d};
      q_nd[q_tail]   = (cfg_data_bits < 5) ? 5 : (cfg_data_bits > 9) ? 9 : int'(cfg_data_bits);
      q_par[q_tail]  = int'(cfg_parity);
      q_two[q_tail]  = cfg_two_stop;
      q_fast[q_tail] = cfg_double_speed;
      q_tail = (q_tail + 1) % 512;
      words_in++;
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_empty();
    while (!buf_empty) @(negedge clk);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!(tx_done && !rx_busy)) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic set_cfg(input int nd, input int par, input bit two, input bit fast);
    cfg_data_bits = 4'(nd); cfg_parity = 2'(par); cfg_two_stop = two; cfg_double_speed = fast;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    checks++; fails++;
    $display("FAIL R6 watchdog expired actual=%0h expected=%0h", frames_rx, words_in);
    summary();
  end

  initial begin
    bit acc;
    int unsigned seed_init;
    seed_init = $urandom(32'd2024);
    rst_n = 1'b0; baud_tick = 1'b0; wr_en = 1'b0; wr_data = '0; wr_bit8 = 1'b0;
    set_cfg(8, 0, 0, 0);
    repeat (4) @(negedge clk);
    chk(tx_out == 1'b1 && buf_empty == 1'b1 && tx_done == 1'b0, "R1", "reset state",
        int'({tx_out, buf_empty, tx_done}), 3'b110);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R8: load timing from idle
    write_word(8'hA5, 1'b0, acc);
    chk(buf_empty == 1'b0 && tx_out == 1'b1, "R8", "word held one cycle", int'({buf_empty, tx_out}), 1);
    @(negedge clk);
    chk(buf_empty == 1'b1 && tx_out == 1'b0, "R8", "transfer and start bit", int'({buf_empty, tx_out}), 2);
    wait_idle();
    chk(tx_done == 1'b1, "R10", "done after idle", int'(tx_done), 1);

    // R7, R9: queued word, ignored write, gapless handover
    set_cfg(7, 2, 1, 1);
    tick_period = 2;
    write_word(8'h3C, 1'b0, acc);
    chk(tx_done == 1'b0, "R10", "done cleared by write", int'(tx_done), 0);
    wait_empty();
    write_word(8'hC3, 1'b0, acc);
    write_word(8'h77, 1'b0, acc);
    chk(acc == 1'b0, "R7", "write into full stage refused", int'(acc), 0);
    wait_idle();

    // R3: 9-bit words differing only in bit 8
    set_cfg(9, 3, 1, 0);
    tick_period = 1;
    write_word(8'h5A, 1'b1, acc);
    wait_empty();
    write_word(8'h5A, 1'b0, acc);
    wait_idle();

    // R3: out-of-range width clamps
    set_cfg(3, 2, 0, 1);
    write_word(8'hFF, 1'b1, acc);
    wait_idle();
    set_cfg(12, 2, 0, 1);
    write_word(8'h81, 1'b1, acc);
    wait_idle();

    // R11: configuration change during a frame
    set_cfg(5, 0, 0, 0);
    write_word(8'h15, 1'b1, acc);
    @(negedge clk);
    set_cfg(9, 2, 1, 1);
    wait_idle();

    // random groups
    for (int g = 0; g < 6; g++) begin
      set_cfg(5 + int'($urandom % 5), int'($urandom % 4), 1'($urandom % 2), 1'($urandom % 2));
      tick_period = 1 + int'($urandom % 2);
      for (int k = 0; k < 10; k++) begin
        if ($urandom % 3 != 0) wait_empty();
        repeat (int'($urandom % 12)) @(negedge clk);
        write_word(8'($urandom), 1'($urandom), acc);
      end
      wait_idle();
    end

    wait_idle();
    chk(frames_rx == words_in && q_head == q_tail, "R7", "frames match accepted words", frames_rx, words_in);
    summary();
  end

endmodule